// File: doc/BRIEF.md
# TFT Line Pulse Timing Generator

This block turns a system clock into the per-line timing signals that a TFT panel's drivers need. It drives three outputs. The gate-driver clock marks each line period. The line-latch pulse tells the source driver when to take in a line. The data-valid window marks the interval in which pixel data is driven on the pixel bus. A line is a whole number of 16-clock blocks. All other timing is counted from the start of the line.

Four programmable values shape the line: the line length, the latch-pulse setup delay, the latch-pulse width and a count of dummy pixel clocks before the first valid pixel. A simple write port loads these values. A write made while the block runs is held back until the current line ends. A mode input selects the alternate behaviour of a zero-width pulse. One pixel clock lasts `PIX_DIV` system clocks (default 2). A line carries `ACTIVE_PIX` valid pixels (default 32).

Top module: `tft_line_timer`

## Requirements
- R1: The gate clock repeats every (S+1)×16 system clocks, where S is the 8-bit value at write address 0. Each period begins with the gate clock high for (S+1)×8 clocks, and the gate clock is low for the rest of the period.
- R2: When the 8-bit width value at address 2 is non-zero, the line pulse rises 15 + 8×T clocks after the gate clock rises. T is the 5-bit setup value at address 1.
- R3: A non-zero width W keeps the line pulse high for 8×W clocks. The pulse is cut off at the end of the line. If the pulse would begin at or after the end of the line, no pulse is produced.
- R4: The data-valid window opens D×2 clocks after the gate clock rises, where D is the 3-bit dummy value at address 3. It stays open for 64 clocks (32 pixels of 2 clocks each) and is cut off at the end of the line.
- R5: With W = 0 and mode_alt low, the line pulse is high exactly when data-valid is high.
- R6: With W = 0 and mode_alt high, the line pulse opens with data-valid but closes 2 clocks (one pixel clock) after it, still cut off at the end of the line.
- R7: A value written while the block is enabled takes effect from the next line, not the current one. A value written while the block is disabled is used from the first line after enable.
- R8: When en is low, all three outputs are low from the next clock edge. When en rises, a new line starts with the gate clock high on the next edge.
- R9: A synchronous reset drives all outputs low and clears all programmed values to 0. With every value at 0, the line is 16 clocks long and both the line pulse and data-valid stay high throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; outputs held low while low |
| mode_alt | input | 1 | Selects the extended zero-width pulse behaviour |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 line length, 1 setup, 2 width, 3 dummy |
| wr_data | input | 8 | Write data, low-aligned to the field width |
| gate_clk | output | 1 | Gate-driver clock, one period per line |
| line_pulse | output | 1 | Source-driver line-latch pulse |
| data_valid | output | 1 | Pixel data valid window |

## Verification
Every output is a registered compare of the line phase, so it changes one edge after the phase reaches the programmed point. The gate clock rises on the first edge after enable or after a wrap. The bench samples on falling edges and takes each line's first high gate-clock sample as index 0. It then measures the pulse and window edges, and the line period, as sample offsets from that index. These offsets match the requirement formulas directly. A new value reaches the outputs only at the next line boundary, so the bench lets one full line pass after each reconfiguration before it measures. The deferred-write check measures the line in which the write happened and then the line after it.

// File: rtl/tft_lt_pkg.sv
package tft_lt_pkg;
  localparam int SCAN_W  = 8;
  localparam int SETUP_W = 5;
  localparam int WIDTH_W = 8;
  localparam int DUMMY_W = 3;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_SCAN  = 2'd0,
    REG_SETUP = 2'd1,
    REG_WIDTH = 2'd2,
    REG_DUMMY = 2'd3
  } lt_reg_e;

  typedef struct packed {
    logic               alt;
    logic [DUMMY_W-1:0] dummy;
    logic [WIDTH_W-1:0] width;
    logic [SETUP_W-1:0] setup;
    logic [SCAN_W-1:0]  scan;
  } lt_cfg_t;
endpackage

// File: rtl/tft_lt_regs.sv
module tft_lt_regs
  import tft_lt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              alt_i,
  input  logic              load_i,
  output lt_cfg_t           act_o
);
  lt_cfg_t prog_q;
  lt_cfg_t act_q;

  // programmed copy: written by the port, mode pin sampled every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q <= '0;
    end else begin
      prog_q.alt <= alt_i;
      if (wr_en) begin
        case (lt_reg_e'(wr_addr))
          REG_SCAN:  prog_q.scan  <= wr_data[SCAN_W-1:0];
          REG_SETUP: prog_q.setup <= wr_data[SETUP_W-1:0];
          REG_WIDTH: prog_q.width <= wr_data[WIDTH_W-1:0];
          REG_DUMMY: prog_q.dummy <= wr_data[DUMMY_W-1:0];
          default:   prog_q.scan  <= prog_q.scan;
        endcase
      end
    end
  end

  // active copy: only refreshed at a line boundary or while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
    end else if (load_i) begin
      act_q <= prog_q;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/tft_lt_phase.sv
module tft_lt_phase #(
  parameter int SCAN_W       = 8,
  parameter int PERIOD_SHIFT = 4,
  localparam int CNT_W       = SCAN_W + PERIOD_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [SCAN_W-1:0] scan,
  output logic [CNT_W-1:0]  phase_o,
  output logic              wrap_o
);
  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] last_ph;

  // (scan+1)*2^PERIOD_SHIFT - 1
  assign last_ph = {scan, {PERIOD_SHIFT{1'b1}}};
  assign wrap_o  = en && (phase_q == last_ph);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase_q <= '0;
    end else if (wrap_o) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/tft_lt_shaper.sv
module tft_lt_shaper
  import tft_lt_pkg::*;
#(
  parameter int OFFSET       = 15,
  parameter int PIX_DIV      = 2,
  parameter int ACTIVE_PIX   = 32,
  parameter int UNIT_SHIFT   = 3,
  parameter int PERIOD_SHIFT = 4,
  parameter int CNT_W        = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] phase,
  input  lt_cfg_t          cfg,
  output logic             gclk_o,
  output logic             lp_o,
  output logic             dv_o
);
  localparam int LP_MAX = OFFSET + ((2**SETUP_W + 2**WIDTH_W) << UNIT_SHIFT);
  localparam int DV_MAX = (2**DUMMY_W + ACTIVE_PIX + 1) * PIX_DIV;
  localparam int TOP    = (LP_MAX > DV_MAX) ? LP_MAX : DV_MAX;
  localparam int EW0    = $clog2(TOP + 1) + 1;
  localparam int EW     = (EW0 > CNT_W + 1) ? EW0 : CNT_W + 1;

  logic [EW-1:0] ph, half, lp_beg, lp_end, dv_beg, dv_end, win_end;
  logic          gclk_d, lp_d, dv_d;

  assign ph      = EW'(phase);
  assign half    = (EW'(cfg.scan) + EW'(1)) << (PERIOD_SHIFT - 1);
  assign lp_beg  = EW'(OFFSET) + (EW'(cfg.setup) << UNIT_SHIFT);
  assign lp_end  = lp_beg + (EW'(cfg.width) << UNIT_SHIFT);

  generate
    if ((PIX_DIV & (PIX_DIV - 1)) == 0) begin : g_pix_shift
      assign dv_beg = EW'(cfg.dummy) << $clog2(PIX_DIV);
    end else begin : g_pix_mul
      assign dv_beg = EW'(cfg.dummy) * EW'(PIX_DIV);
    end
  endgenerate

  assign dv_end  = dv_beg + EW'(ACTIVE_PIX * PIX_DIV);
  assign win_end = dv_end + (cfg.alt ? EW'(PIX_DIV) : EW'(0));

  always_comb begin
    gclk_d = (ph < half);
    dv_d   = (ph >= dv_beg) && (ph < dv_end);
    if (cfg.width == '0) begin
      lp_d = (ph >= dv_beg) && (ph < win_end);
    end else begin
      lp_d = (ph >= lp_beg) && (ph < lp_end);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gclk_o <= 1'b0;
      lp_o   <= 1'b0;
      dv_o   <= 1'b0;
    end else begin
      gclk_o <= gclk_d;
      lp_o   <= lp_d;
      dv_o   <= dv_d;
    end
  end
endmodule

// File: rtl/tft_line_timer.sv
module tft_line_timer
  import tft_lt_pkg::*;
#(
  parameter int OFFSET       = 15,
  parameter int PIX_DIV      = 2,
  parameter int ACTIVE_PIX   = 32,
  parameter int UNIT_SHIFT   = 3,
  parameter int PERIOD_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              mode_alt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              gate_clk,
  output logic              line_pulse,
  output logic              data_valid
);
  localparam int CNT_W = SCAN_W + PERIOD_SHIFT;

  lt_cfg_t          act_cfg;
  logic [CNT_W-1:0] phase;
  logic             wrap;
  logic             load;

  assign load = !en || wrap;

  tft_lt_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .alt_i   (mode_alt),
    .load_i  (load),
    .act_o   (act_cfg)
  );

  tft_lt_phase #(
    .SCAN_W       (SCAN_W),
    .PERIOD_SHIFT (PERIOD_SHIFT)
  ) u_phase (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .scan    (act_cfg.scan),
    .phase_o (phase),
    .wrap_o  (wrap)
  );

  tft_lt_shaper #(
    .OFFSET       (OFFSET),
    .PIX_DIV      (PIX_DIV),
    .ACTIVE_PIX   (ACTIVE_PIX),
    .UNIT_SHIFT   (UNIT_SHIFT),
    .PERIOD_SHIFT (PERIOD_SHIFT),
    .CNT_W        (CNT_W)
  ) u_shaper (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .phase  (phase),
    .cfg    (act_cfg),
    .gclk_o (gate_clk),
    .lp_o   (line_pulse),
    .dv_o   (data_valid)
  );
endmodule

// File: rtl/tft_line_timer_chk.sv
module tft_line_timer_chk #(
  parameter int SCAN_W       = 8,
  parameter int WIDTH_W      = 8,
  parameter int PERIOD_SHIFT = 4,
  localparam int PW          = SCAN_W + PERIOD_SHIFT + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic               gate_clk,
  input logic               line_pulse,
  input logic               data_valid,
  input logic [SCAN_W-1:0]  act_scan,
  input logic [WIDTH_W-1:0] act_width,
  input logic               act_alt
);
  logic          gclk_q;
  logic          tracked;
  logic [PW-1:0] since_rise;
  logic [PW-1:0] high_run;
  logic [PW-1:0] exp_per;
  logic          g_rise, g_fall;

  assign g_rise = gate_clk && !gclk_q;
  assign g_fall = !gate_clk && gclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gclk_q     <= 1'b0;
      tracked    <= 1'b0;
      since_rise <= '0;
      high_run   <= '0;
      exp_per    <= '0;
    end else begin
      gclk_q <= gate_clk;
      if (!en) begin
        tracked <= 1'b0;
      end else if (g_rise) begin
        tracked <= 1'b1;
      end
      if (g_rise) begin
        since_rise <= PW'(1);
        high_run   <= PW'(1);
        exp_per    <= (PW'(act_scan) + PW'(1)) << PERIOD_SHIFT;
      end else begin
        since_rise <= since_rise + PW'(1);
        if (gate_clk) high_run <= high_run + PW'(1);
      end
    end
  end

  // R1: consecutive gate clock rises are one programmed line apart
  assert_period_R1: assert property (@(posedge clk) disable iff (rst)
    (g_rise && tracked && en) |-> (since_rise == exp_per));

  // R1: gate clock high for half of the line
  assert_gclk_high_R1: assert property (@(posedge clk) disable iff (rst)
    (g_fall && tracked && en) |-> (high_run == (exp_per >> 1)));

  // R5: zero width in normal mode makes the pulse follow the data window
  assert_zero_width_R5: assert property (@(posedge clk) disable iff (rst)
    $past(en && !rst && (act_width == '0) && !act_alt) |-> (line_pulse == data_valid));

  // R8: disabled means all outputs low on the next edge
  assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!gate_clk && !line_pulse && !data_valid));

  // R9: reset clears the outputs
  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!gate_clk && !line_pulse && !data_valid));
endmodule

bind tft_line_timer tft_line_timer_chk #(
  .SCAN_W       (tft_lt_pkg::SCAN_W),
  .WIDTH_W      (tft_lt_pkg::WIDTH_W),
  .PERIOD_SHIFT (PERIOD_SHIFT)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .gate_clk   (gate_clk),
  .line_pulse (line_pulse),
  .data_valid (data_valid),
  .act_scan   (act_cfg.scan),
  .act_width  (act_cfg.width),
  .act_alt    (act_cfg.alt)
);

// File: tb/tft_line_timer_tb_top.sv
module tft_line_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       mode_alt = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       gate_clk, line_pulse, data_valid;

  int n_chk  = 0;
  int n_fail = 0;
  logic last_g = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tft_line_timer dut_i (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .mode_alt   (mode_alt),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .gate_clk   (gate_clk),
    .line_pulse (line_pulse),
    .data_valid (data_valid)
  );

  typedef struct packed {
    logic [7:0] scan;
    logic [4:0] setup;
    logic [7:0] width;
    logic [2:0] dummy;
    logic       alt;
    int per; int gh; int lpo; int lpl; int dvo; int dvl;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd7, 5'd2,  8'd3, 3'd3, 1'b0, 128, 64, 31, 24,  6, 64},
    '{8'd9, 5'd0,  8'd1, 3'd0, 1'b0, 160, 80, 15,  8,  0, 64},
    '{8'd7, 5'd5,  8'd0, 3'd5, 1'b0, 128, 64, 10, 64, 10, 64},
    '{8'd7, 5'd5,  8'd0, 3'd5, 1'b1, 128, 64, 10, 66, 10, 64},
    '{8'd4, 5'd31, 8'd2, 3'd1, 1'b0,  80, 40,  0,  0,  2, 64},
    '{8'd5, 5'd8,  8'd4, 3'd7, 1'b0,  96, 48, 79, 17, 14, 64},
    '{8'd3, 5'd1,  8'd0, 3'd2, 1'b1,  64, 32,  4, 60,  4, 60}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise();
    bit seen = 1'b0;
    last_g = gate_clk;
    while (!seen) begin
      @(negedge clk);
      if (gate_clk && !last_g) seen = 1'b1;
      last_g = gate_clk;
    end
  endtask

  // sample index 0 is the first high gate clock sample of the line
  task automatic measure(input int mid_k, input logic [1:0] ma, input logic [7:0] md,
                         output int per, output int gh, output int lpo,
                         output int lpl, output int dvo, output int dvl);
    wait_rise();
    per = 0; gh = 0; lpo = -1; lpl = 0; dvo = -1; dvl = 0;
    for (int k = 0; k < 6000; k++) begin
      if (k > 0) begin
        @(negedge clk);
        if (gate_clk && !last_g) begin
          per = k;
          last_g = gate_clk;
          break;
        end
        last_g = gate_clk;
      end
      if (k == mid_k) begin
        wr_en = 1'b1; wr_addr = ma; wr_data = md;
      end else if (k == mid_k + 1) begin
        wr_en = 1'b0;
      end
      if (gate_clk) gh++;
      if (line_pulse) begin
        if (lpo < 0) lpo = k;
        lpl++;
      end
      if (data_valid) begin
        if (dvo < 0) dvo = k;
        dvl++;
      end
    end
  endtask

  task automatic load_cfg(input vec_t v);
    mode_alt = v.alt;
    wr(2'd0, v.scan);
    wr(2'd1, 8'(v.setup));
    wr(2'd2, v.width);
    wr(2'd3, 8'(v.dummy));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int per, gh, lpo, lpl, dvo, dvl;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset gate_clk", int'(gate_clk), 0);
    chk("R9 reset line_pulse", int'(line_pulse), 0);
    chk("R9 reset data_valid", int'(data_valid), 0);
    rst = 1'b0;
    en = 1'b1;

    // all-zero configuration after reset
    measure(-1, 2'd0, 8'd0, per, gh, lpo, lpl, dvo, dvl);
    chk("R9 zero cfg period", per, 16);
    chk("R9 zero cfg gate high", gh, 8);
    chk("R9 zero cfg pulse start", lpo, 0);
    chk("R9 zero cfg pulse length", lpl, 16);
    chk("R9 zero cfg valid length", dvl, 16);

    // table of configurations
    for (int i = 0; i < NV; i++) begin
      load_cfg(VECS[i]);
      wait_rise();
      measure(-1, 2'd0, 8'd0, per, gh, lpo, lpl, dvo, dvl);
      chk("R1 period", per, VECS[i].per);
      chk("R1 gate high", gh, VECS[i].gh);
      chk("R4 valid start", dvo, VECS[i].dvo);
      chk("R4 valid length", dvl, VECS[i].dvl);
      if (VECS[i].width != 0) begin
        chk("R3 pulse length", lpl, VECS[i].lpl);
        if (VECS[i].lpl != 0) chk("R2 pulse start", lpo, VECS[i].lpo);
      end else if (VECS[i].alt) begin
        chk("R6 pulse start", lpo, VECS[i].lpo);
        chk("R6 pulse length", lpl, VECS[i].lpl);
      end else begin
        chk("R5 pulse start", lpo, VECS[i].lpo);
        chk("R5 pulse length", lpl, VECS[i].lpl);
      end
    end

    // R7: write in the middle of a line is deferred to the next line
    load_cfg(VECS[0]);
    wait_rise();
    measure(3, 2'd1, 8'd10, per, gh, lpo, lpl, dvo, dvl);
    chk("R7 current line keeps old setup", lpo, 31);
    measure(-1, 2'd0, 8'd0, per, gh, lpo, lpl, dvo, dvl);
    chk("R7 next line uses new setup", lpo, 95);
    chk("R7 next line pulse length", lpl, 24);

    // R8: disable, write while idle, re-enable
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R8 idle gate_clk", int'(gate_clk), 0);
    chk("R8 idle line_pulse", int'(line_pulse), 0);
    chk("R8 idle data_valid", int'(data_valid), 0);
    wr(2'd1, 8'd0);
    wr(2'd2, 8'd2);
    @(negedge clk);
    chk("R8 still idle after writes", int'(line_pulse | gate_clk), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R8 line restarts gate high", int'(gate_clk), 1);
    chk("R8 line restarts pulse low", int'(line_pulse), 0);
    measure(-1, 2'd0, 8'd0, per, gh, lpo, lpl, dvo, dvl);
    chk("R7 idle write pulse start", lpo, 15);
    chk("R7 idle write pulse length", lpl, 16);
    chk("R7 idle write period", per, 128);

    // R9: reset during operation clears the programmed values
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 mid reset gate_clk", int'(gate_clk), 0);
    chk("R9 mid reset line_pulse", int'(line_pulse), 0);
    rst = 1'b0;
    measure(-1, 2'd0, 8'd0, per, gh, lpo, lpl, dvo, dvl);
    chk("R9 post reset period", per, 16);
    chk("R9 post reset valid length", dvl, 16);

    finish_run();
  end
endmodule